// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss by fetching page table entries from memory. A 32-bit virtual address is split into a 10-bit directory index (bits 31:22), a 10-bit leaf index (bits 21:12) and a 12-bit page offset (bits 11:0). Each entry is 4 bytes, so each table holds 1024 entries and fills exactly one 4 KB page. The walker reads a directory entry from the table named by the page-table base register. If that entry is present, it reads a leaf entry from the table the directory entry points at. It then either returns the physical address (frame number with the untouched offset) or a fault code.

Page replacement software relies on the used and dirty bits in each leaf entry, and the walker maintains them itself. Any permitted access sets the used bit, and a permitted write also sets the dirty bit. The leaf entry is written back to memory only when one of these bits actually changes. The memory side is a single-outstanding read/write port. The request side takes one walk at a time.

Entry layout shared by both levels: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 used, bit 4 dirty, bits 31:12 frame number. Bits 11:5 are carried but not interpreted. Result codes on `rsp_fault`: 0 success, 1 page fault (entry not present), 2 protection fault.

Top module: `pt_walker`

## Requirements
- R1: A walk is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its first memory access is a read at `{pt_base[31:12], vaddr[31:22], 2'b00}`.
- R2: If the directory entry has bit 0 clear, the walk ends with code 1 after that single read. In a directory entry, only bit 0 and bits 31:12 have any effect.
- R3: If the directory entry is present, the second access is a read at `{dir_entry[31:12], vaddr[21:12], 2'b00}`.
- R4: If the leaf entry has bit 0 clear, the walk ends with code 1 and no write is issued, whatever the other leaf bits are.
- R5: If the leaf is present and either the request is a write to an entry with bit 1 clear, or a user request targets an entry with bit 2 clear, the walk ends with code 2 and no write is issued. Not-present takes priority over protection.
- R6: On success the result is code 0 with `rsp_paddr = {leaf[31:12], vaddr[11:0]}`. On any fault `rsp_paddr` is zero.
- R7: On success the leaf's bit 3 is set, and on a write request bit 4 is also set. All other leaf bits are kept, and the updated entry is written to the address the leaf was read from.
- R8: The write-back is issued only if it changes the stored entry. Otherwise a successful walk makes exactly two reads.
- R9: `mem_req` stays high with a steady address and write flag until `mem_ack`. Only one access is in flight, and `mem_we` is high only for the leaf write-back.
- R10: After reset `req_ready` is high, and `rsp_done` and `mem_req` are low. `rsp_done` is a one-cycle pulse, `req_ready` is low from acceptance until that pulse ends, and it is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_base | input | 32 | Page-table base register value (4 KB aligned) |
| req_valid | input | 1 | Walk request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data (updated leaf entry) |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| rsp_done | output | 1 | Walk finished, result valid |
| rsp_fault | output | 2 | 0 success, 1 page fault, 2 protection fault |
| rsp_paddr | output | 32 | Physical address on success |

## Verification
The permission verdict and the used/dirty update are decided from the same leaf read in the same cycle. A fault must therefore suppress an update that would otherwise be needed. The bench sweeps all 32 combinations of the five leaf flag bits against all four write/user request kinds, and varies the memory latency. For each walk it predicts, from the flag arithmetic, the fault code, the physical address and the exact access sequence. It then judges the outcome by the logged accesses and by reading the leaf word back from its memory model.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_LEAF,
    ST_UPD,
    ST_RESP
  } walk_st_e;

  localparam int unsigned BIT_PRES  = 0;
  localparam int unsigned BIT_WR    = 1;
  localparam int unsigned BIT_USER  = 2;
  localparam int unsigned BIT_USED  = 3;
  localparam int unsigned BIT_DIRTY = 4;
endpackage

// File: rtl/pw_rst_sync.sv
`timescale 1ns/1ps
module pw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pw_addr_gen.sv
`timescale 1ns/1ps
module pw_addr_gen #(
  parameter  int ADDR_W  = 32,
  parameter  int IDX_W   = 10,
  parameter  int OFF_W   = 12,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic               leaf_lvl,
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [ADDR_W-1:0]  vaddr,
  output logic [ADDR_W-1:0]  addr
);
  localparam int LEVELS = 2;
  localparam int PAD_W  = OFF_W - IDX_W;

  logic [IDX_W-1:0] lvl_idx [LEVELS];

  // level 0 takes the upper index field, level 1 the one below it
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
    assign lvl_idx[lv] = vaddr[OFF_W + (LEVELS-1-lv)*IDX_W +: IDX_W];
  end

  logic [IDX_W-1:0] sel_idx;
  assign sel_idx = leaf_lvl ? lvl_idx[1] : lvl_idx[0];
  assign addr    = {base_frame, sel_idx, {PAD_W{1'b0}}};
endmodule

// File: rtl/pw_perm.sv
`timescale 1ns/1ps
module pw_perm
  import pw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pte,
  input  logic              is_write,
  input  logic              is_user,
  output fault_e            verdict,
  output logic              upd_need,
  output logic [ADDR_W-1:0] upd_pte
);
  always_comb begin
    upd_pte           = pte;
    upd_pte[BIT_USED] = 1'b1;
    if (is_write) upd_pte[BIT_DIRTY] = 1'b1;
    upd_need = (upd_pte != pte);

    if (!pte[BIT_PRES])
      verdict = FLT_PAGE;
    else if ((is_write && !pte[BIT_WR]) || (is_user && !pte[BIT_USER]))
      verdict = FLT_PROT;
    else
      verdict = FLT_NONE;
  end
endmodule

// File: rtl/pw_ctrl.sv
`timescale 1ns/1ps
module pw_ctrl
  import pw_pkg::*;
#(
  parameter  int ADDR_W  = 32,
  parameter  int OFF_W   = 12,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [ADDR_W-1:0]  pt_base,
  output logic               req_ready,
  input  logic               mem_ack,
  input  logic [ADDR_W-1:0]  mem_rdata,
  input  logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_wdata,
  input  fault_e             verdict,
  input  logic               upd_need,
  input  logic [ADDR_W-1:0]  upd_pte,
  output logic               leaf_lvl,
  output logic [FRAME_W-1:0] base_frame,
  output logic [ADDR_W-1:0]  vaddr_q,
  output logic               write_q,
  output logic               user_q,
  output logic               rsp_done,
  output fault_e             rsp_fault,
  output logic [ADDR_W-1:0]  rsp_paddr
);
  walk_st_e           state_q, state_d;
  logic [FRAME_W-1:0] root_q, table_q;
  logic [ADDR_W-1:0]  wb_q, paddr_q, paddr_d;
  fault_e             fault_q, fault_d;
  logic               req_ld, table_ld, wb_ld, res_ld;

  // next-state and load enables
  always_comb begin
    state_d  = state_q;
    req_ld   = 1'b0;
    table_ld = 1'b0;
    wb_ld    = 1'b0;
    res_ld   = 1'b0;
    fault_d  = FLT_NONE;
    paddr_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          req_ld  = 1'b1;
          state_d = ST_DIR;
        end
      end
      ST_DIR: begin
        if (mem_ack) begin
          if (mem_rdata[BIT_PRES]) begin
            table_ld = 1'b1;
            state_d  = ST_LEAF;
          end else begin
            res_ld  = 1'b1;
            fault_d = FLT_PAGE;
            state_d = ST_RESP;
          end
        end
      end
      ST_LEAF: begin
        if (mem_ack) begin
          res_ld  = 1'b1;
          fault_d = verdict;
          if (verdict == FLT_NONE) begin
            paddr_d = {mem_rdata[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
            if (upd_need) begin
              wb_ld   = 1'b1;
              state_d = ST_UPD;
            end else begin
              state_d = ST_RESP;
            end
          end else begin
            state_d = ST_RESP;
          end
        end
      end
      ST_UPD: begin
        if (mem_ack) state_d = ST_RESP;
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      write_q <= 1'b0;
      user_q  <= 1'b0;
      root_q  <= '0;
    end else if (req_ld) begin
      vaddr_q <= req_vaddr;
      write_q <= req_write;
      user_q  <= req_user;
      root_q  <= pt_base[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        table_q <= '0;
    else if (table_ld) table_q <= mem_rdata[ADDR_W-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wb_q <= '0;
    else if (wb_ld) wb_q <= upd_pte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else if (res_ld) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  // outputs
  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_DIR) || (state_q == ST_LEAF) || (state_q == ST_UPD);
  assign mem_we     = (state_q == ST_UPD);
  assign mem_wdata  = wb_q;
  assign leaf_lvl   = (state_q != ST_DIR);
  assign base_frame = (state_q == ST_DIR) ? root_q : table_q;
  assign rsp_done   = (state_q == ST_RESP);
  assign rsp_fault  = fault_q;
  assign rsp_paddr  = paddr_q;

  // R9: request held steady until acknowledged
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R8: a write is entered only right after an acknowledged leaf read
  a_r8_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_ack && !mem_we));

  // R7: every write-back carries the used bit, and the dirty bit on writes
  a_r7_wb_used: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[BIT_USED]);
  a_r7_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && write_q) |-> mem_wdata[BIT_DIRTY]);

  // R5: a faulting walk never ends on a write
  a_r5_no_wb_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault != FLT_NONE) |-> !$past(mem_we));

  // R6: fault results carry a zero address
  a_r6_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

  // R10: one-cycle completion, walker free right after
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));
  a_r10_busy_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              req_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_done,
  output logic [1:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic               rst_n_s;
  logic               leaf_lvl;
  logic [FRAME_W-1:0] base_frame;
  logic [ADDR_W-1:0]  vaddr_q;
  logic               write_q, user_q;
  fault_e             verdict, fault_o;
  logic               upd_need;
  logic [ADDR_W-1:0]  upd_pte;

  pw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pw_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .leaf_lvl   (leaf_lvl),
    .base_frame (base_frame),
    .vaddr      (vaddr_q),
    .addr       (mem_addr)
  );

  pw_perm #(.ADDR_W(ADDR_W)) u_perm (
    .pte      (mem_rdata),
    .is_write (write_q),
    .is_user  (user_q),
    .verdict  (verdict),
    .upd_need (upd_need),
    .upd_pte  (upd_pte)
  );

  pw_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_write  (req_write),
    .req_user   (req_user),
    .pt_base    (pt_base),
    .req_ready  (req_ready),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .verdict    (verdict),
    .upd_need   (upd_need),
    .upd_pte    (upd_pte),
    .leaf_lvl   (leaf_lvl),
    .base_frame (base_frame),
    .vaddr_q    (vaddr_q),
    .write_q    (write_q),
    .user_q     (user_q),
    .rsp_done   (rsp_done),
    .rsp_fault  (fault_o),
    .rsp_paddr  (rsp_paddr)
  );

  assign rsp_fault = fault_o;
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pt_base;
  logic        req_valid, req_write, req_user;
  logic [31:0] req_vaddr;
  logic        req_ready, mem_req, mem_we, rsp_done;
  logic [31:0] mem_addr, mem_wdata, rsp_paddr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic [1:0]  rsp_fault;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_user(req_user), .req_ready(req_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  int checks = 0;
  int errors = 0;

  // memory model: 16 KB, word-indexed by address bits 13:2
  logic [31:0] mem [0:4095];
  int          lat = 0;
  int          lat_cnt = 0;
  int          n_acc = 0;
  logic [31:0] log_addr [0:7];
  logic        log_we   [0:7];

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (lat_cnt >= lat) begin
          lat_cnt = 0;
          if (n_acc < 8) begin
            log_addr[n_acc] = mem_addr;
            log_we[n_acc]   = mem_we;
          end
          n_acc = n_acc + 1;
          if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
          mem_rdata = mem[mem_addr[13:2]];
          mem_ack   = 1'b1;
        end else begin
          lat_cnt = lat_cnt + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // issue one walk and return its result
  task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                      output logic [1:0] f, output logic [31:0] pa);
    int cyc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    n_acc     = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    req_write = wr;
    req_user  = usr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", {31'd0, req_ready}, 32'd0);
    cyc = 0;
    while (!rsp_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(rsp_done == 1'b1, "R10 walk completes", {31'd0, rsp_done}, 32'd1);
    f  = rsp_fault;
    pa = rsp_paddr;
    @(negedge clk);
    chk(!rsp_done && req_ready, "R10 done pulse then ready",
        {30'd0, rsp_done, req_ready}, 32'd1);
  endtask

  initial begin
    logic [1:0]  f;
    logic [31:0] pa;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    rst_n = 1'b0; pt_base = '0; req_valid = 1'b0; req_vaddr = '0;
    req_write = 1'b0; req_user = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_done && !mem_req, "R10 reset state",
        {29'd0, req_ready, rsp_done, mem_req}, 32'd4);

    // sweep: directory at 0x0000, leaf table at 0x2000
    for (int k = 0; k < 128; k++) begin
      logic [4:0]  flg;
      bit          wr, usr, okp;
      logic [9:0]  i1, i2;
      logic [11:0] off;
      logic [31:0] va, dir_e, leaf, nleaf, exp_pa, l1a, l2a;
      logic [1:0]  exp_f;
      int          exp_n;
      flg = k[4:0]; wr = k[5]; usr = k[6];
      i1  = 10'((k * 37) % 1024);
      i2  = 10'((k * 91 + 5) % 1024);
      off = 12'((k * 293) % 4096);
      va  = {i1, i2, off};
      dir_e = {20'h00002, 11'(k * 5), 1'b1};
      leaf  = {20'(32'h12345 + k), 7'(k), flg};
      pt_base = 32'h0000_0000;
      mem[{2'b00, i1}] = dir_e;
      mem[{2'b10, i2}] = leaf;
      l1a = {20'h00000, i1, 2'b00};
      l2a = {20'h00002, i2, 2'b00};
      lat = k % 3;
      // expected outcome from the flag arithmetic
      nleaf = leaf | 32'h8 | (wr ? 32'h10 : 32'h0);
      if (!flg[0]) begin
        exp_f = 2'd1; okp = 0;
      end else if ((wr && !flg[1]) || (usr && !flg[2])) begin
        exp_f = 2'd2; okp = 0;
      end else begin
        exp_f = 2'd0; okp = 1;
      end
      exp_pa = okp ? {leaf[31:12], off} : 32'd0;
      exp_n  = (okp && nleaf != leaf) ? 3 : 2;
      walk(va, wr, usr, f, pa);
      chk(f == exp_f, !flg[0] ? "R4 leaf absent code" : "R5 R6 fault code",
          {30'd0, f}, {30'd0, exp_f});
      chk(pa == exp_pa, "R6 physical address", pa, exp_pa);
      chk(log_addr[0] == l1a && !log_we[0], "R1 directory read address", log_addr[0], l1a);
      chk(log_addr[1] == l2a && !log_we[1], "R3 leaf read address", log_addr[1], l2a);
      chk(n_acc == exp_n, "R8 access count", 32'(n_acc), 32'(exp_n));
      if (exp_n == 3)
        chk(log_addr[2] == l2a && log_we[2], "R9 write-back address", log_addr[2], l2a);
      chk(mem[{2'b10, i2}] == (okp ? nleaf : leaf), okp ? "R7 updated leaf" : "R5 leaf untouched",
          mem[{2'b10, i2}], okp ? nleaf : leaf);
    end

    // directory entry absent, root at 0x3000
    for (int k = 0; k < 6; k++) begin
      logic [31:0] va, l1a;
      logic [9:0]  i1;
      i1 = 10'(k * 150 + 3);
      va = {i1, 10'(k * 7), 12'(k * 100)};
      pt_base = 32'h0000_3000;
      mem[{2'b11, i1}] = {20'h00001, 11'h7FF, 1'b0};
      l1a = {20'h00003, i1, 2'b00};
      lat = k % 3;
      walk(va, k[0], k[1], f, pa);
      chk(f == 2'd1, "R2 directory absent code", {30'd0, f}, 32'd1);
      chk(pa == 32'd0, "R6 zero address on fault", pa, 32'd0);
      chk(n_acc == 1 && log_addr[0] == l1a, "R2 single read at root", log_addr[0], l1a);
    end

    // root at 0x3000 pointing to leaf table at 0x1000, present leaf
    for (int k = 0; k < 4; k++) begin
      logic [31:0] va, leaf, l2a, exp_pa;
      logic [9:0]  i1, i2;
      i1 = 10'(k * 200 + 9);
      i2 = 10'(k * 111 + 1);
      va = {i1, i2, 12'hABC};
      pt_base = 32'h0000_3000;
      mem[{2'b11, i1}] = {20'h00001, 11'h155, 1'b1};
      leaf = {20'(32'hFEED0 + k), 7'h00, 5'b11111};
      mem[{2'b01, i2}] = leaf;
      l2a = {20'h00001, i2, 2'b00};
      exp_pa = {leaf[31:12], 12'hABC};
      lat = k % 3;
      walk(va, 1'b1, 1'b1, f, pa);
      chk(f == 2'd0 && pa == exp_pa, "R6 translation via root 0x3000", pa, exp_pa);
      chk(n_acc == 2 && log_addr[1] == l2a, "R8 no write when bits already set",
          32'(n_acc), 32'd2);
    end

    finish_run();
  end
endmodule